// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch path and a display pipeline. It accepts 32-bit words holding packed pixels and emits one pixel per clock. A 3-bit format code gives the pixel depth and colour layout. At depths of 8 bits or less the block emits a palette index. For direct-colour formats it emits 8-bit red, green and blue components.

Control inputs select three options: a red/blue component swap, byte-reversed word order, and reversed pixel order inside each byte. A build-time parameter picks between two variants. In the base variant the 16-bit modes are reinterpreted by an external 2-bit layout-select input. In the later variant the format code alone decides, and codes 6 and 7 add dedicated 5:6:5 and 4:4:4 modes. A combinational side output gives the bytes occupied by one display line for the current format and panel width.

The block takes its format and option settings from the inputs in the cycle a word is accepted, and holds them until the last pixel of that word has left.

Top module: `pix_unpack`

## Requirements
- R1: `word_ready` is high whenever no word is held, and also in the cycle the last pixel of a held word is on the output. A word accepted at a clock edge puts its first pixel on the output during the next cycle, and the pixels follow one per cycle with `pix_valid` high and no gaps. A word offered during the last-pixel cycle is accepted at that edge, so back-to-back words stream without a bubble.
- R2: The number of pixels per word depends on the format code. Codes 0 to 3 give 32, 16, 8 and 4 pixels (1, 2, 4 and 8 bits each). Code 5 gives 1 pixel of 32 bits. Codes 4, 6 and 7 give 2 pixels, each in a 16-bit container.
- R3: With both order options clear, pixel k of a word occupies bits [k*w +: w], where w is the container width.
- R4: When `be_byte` is high, the four bytes of the word are reversed before extraction, so byte 3 becomes byte 0. `be_byte` takes priority: `be_pixel` then has no effect.
- R5: When `be_pixel` is high and `be_byte` is low, pixels narrower than a byte are taken from the most significant end of each byte first. The bytes themselves are still taken from least significant to most significant. At 8 bits or wider, `be_pixel` has no effect.
- R6: In the palettised formats (codes 0 to 3), `pix_index` carries the pixel value zero-extended to 8 bits, and `pix_r`, `pix_g` and `pix_b` are zero.
- R7: In code 5, bits [7:0], [15:8] and [23:16] are the low, middle and high components, and bits [31:24] are ignored. With `swap_rb` low, red is the low component and blue the high one. With `swap_rb` high they trade places. In every direct-colour format `pix_index` is zero.
- R8: In the 5:5:5:1 layout the low, middle and high components are bits [4:0], [9:5] and [14:10], and bit 15 is ignored. Each 5-bit component is widened to 8 bits as {c, c[4:2]}. The red/blue assignment follows R7.
- R9: In the 5:6:5 layout the fields are [4:0], [10:5] and [15:11]. The 6-bit middle component is widened as {c, c[5:4]}. In the 4:4:4 layout the fields are [3:0], [7:4] and [11:8], and each is widened as {c, c}. Bits [15:12] are ignored. The red/blue assignment follows R7.
- R10: In the base variant (LATER_VARIANT=0), codes 4, 6 and 7 all decode through `mux_sel`. A value of 1 selects 5:5:5:1 and honours `swap_rb`. A value of 3 selects 5:6:5 with red/blue swap forced on. Values 0 and 2 select 5:6:5 and honour `swap_rb`.
- R11: In the later variant (LATER_VARIANT=1), code 4 is 5:5:5:1, code 6 is 5:6:5 and code 7 is 4:4:4, and `mux_sel` has no effect.
- R12: `line_bytes` equals `panel_cols` divided by 8, 4 and 2 for codes 0, 1 and 2. It equals `panel_cols` for code 3, twice it for codes 4, 6 and 7, and four times it for code 5.
- R13: The format code, the option inputs and `mux_sel` are sampled when a word is accepted. Changing them while the word is being unpacked alters neither its pixel count nor its pixel values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_code | input | 3 | Pixel format code |
| swap_rb | input | 1 | Red/blue component swap |
| be_byte | input | 1 | Reverse byte order within the word |
| be_pixel | input | 1 | Reverse sub-byte pixel order within each byte |
| mux_sel | input | 2 | 16-bit layout select (base variant only) |
| panel_cols | input | COLS_W | Panel width in pixels |
| line_bytes | output | COLS_W+2 | Bytes per display line |
| word_in | input | 32 | Framebuffer word |
| word_valid | input | 1 | Word offered |
| word_ready | output | 1 | Word can be accepted |
| pix_valid | output | 1 | Pixel present on outputs |
| pix_index | output | 8 | Palette index |
| pix_r | output | 8 | Red component |
| pix_g | output | 8 | Green component |
| pix_b | output | 8 | Blue component |

## Verification
Two events can fall in the same cycle: the output of a word's last pixel and the acceptance of the following word. The bench provokes this by holding `word_valid` high with a second word at both 8 bpp and 32 bpp. It judges the result by `word_ready` being low on earlier pixels and high on the last one, and by the first pixel of the new word appearing in the very next cycle. A related overlap is a change of format inputs during unpacking. This is driven one cycle after acceptance and judged by the pixel values and pixel count of the word already held.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTES_W = WORD_W / 8;
  localparam int CNT_W   = $clog2(WORD_W);

  typedef enum logic [2:0] {
    LAY_PAL  = 3'd0,
    LAY_1555 = 3'd1,
    LAY_565  = 3'd2,
    LAY_444  = 3'd3,
    LAY_888  = 3'd4
  } layout_e;

  // Per-word unpack settings, captured with the word.
  typedef struct packed {
    logic [2:0] wlog;     // log2 of container width in bits
    layout_e    layout;
    logic       swap;     // red takes the high component
    logic       be_byte;
    logic       be_pix;
  } pix_cfg_t;

endpackage

// File: rtl/pix_fmt_decode.sv
module pix_fmt_decode
  import pix_unpack_pkg::*;
#(
  parameter bit LATER = 1'b0
) (
  input  logic [2:0] fmt,
  input  logic       bgr,
  input  logic       be_byte,
  input  logic       be_pix,
  input  logic [1:0] mux,
  output pix_cfg_t   cfg
);

  generate
    if (LATER) begin : g_later
      always_comb begin
        cfg.be_byte = be_byte;
        cfg.be_pix  = be_pix;
        cfg.swap    = bgr;
        cfg.wlog    = fmt;
        cfg.layout  = LAY_PAL;
        case (fmt)
          3'd4:    begin cfg.wlog = 3'd4; cfg.layout = LAY_1555; end
          3'd5:    begin cfg.wlog = 3'd5; cfg.layout = LAY_888;  end
          3'd6:    begin cfg.wlog = 3'd4; cfg.layout = LAY_565;  end
          3'd7:    begin cfg.wlog = 3'd4; cfg.layout = LAY_444;  end
          default: ;
        endcase
      end
    end else begin : g_base
      always_comb begin
        cfg.be_byte = be_byte;
        cfg.be_pix  = be_pix;
        cfg.swap    = bgr;
        cfg.wlog    = fmt;
        cfg.layout  = LAY_PAL;
        case (fmt)
          3'd0, 3'd1, 3'd2, 3'd3: ;
          3'd5: begin cfg.wlog = 3'd5; cfg.layout = LAY_888; end
          default: begin
            cfg.wlog = 3'd4;
            case (mux)
              2'd1:    cfg.layout = LAY_1555;
              2'd3:    begin cfg.layout = LAY_565; cfg.swap = 1'b1; end
              default: cfg.layout = LAY_565;
            endcase
          end
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/pix_word_seq.sv
module pix_word_seq
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  pix_cfg_t          cfg_in,
  output logic              in_ready,
  output logic              busy,
  output logic [WORD_W-1:0] word_q,
  output pix_cfg_t          cfg_q,
  output logic [CNT_W-1:0]  cnt_q
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_idx;
  logic             last;
  logic             take;

  always_comb begin
    last_idx = CNT_W'((WORD_W >> cfg_q.wlog) - 1);
    last     = busy_q && (cnt_q == last_idx);
    in_ready = !busy_q || last;
    take     = in_valid && in_ready;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (take) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // Data holding registers: no reset, explicit load enable.
  always_ff @(posedge clk) begin
    if (take) begin
      word_q <= in_data;
      cfg_q  <= cfg_in;
    end
  end

  assign busy = busy_q;

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !in_ready) |=> ($stable(word_q) && $stable(cfg_q)));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= last_idx));

endmodule

// File: rtl/pix_extract.sv
module pix_extract
  import pix_unpack_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  pix_cfg_t          cfg,
  input  logic [CNT_W-1:0]  idx,
  output logic [23:0]       raw
);

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] src;
  logic [CNT_W-1:0]  sub_mask;
  logic [CNT_W-1:0]  slot;
  logic [9:0]        shamt;
  logic [5:0]        pwidth;
  logic [WORD_W-1:0] mask;

  generate
    for (genvar b = 0; b < BYTES_W; b++) begin : g_bswap
      assign swapped[b*8 +: 8] = word[(BYTES_W-1-b)*8 +: 8];
    end
  endgenerate

  always_comb begin
    src      = cfg.be_byte ? swapped : word;
    sub_mask = (cfg.wlog < 3'd3) ? CNT_W'((8 >> cfg.wlog) - 1) : '0;
    slot     = (cfg.be_pix && !cfg.be_byte) ? (idx ^ sub_mask) : idx;
    shamt    = 10'(slot) << cfg.wlog;
    pwidth   = 6'd1 << cfg.wlog;
    mask     = ~({WORD_W{1'b1}} << pwidth);
    raw      = 24'((src >> shamt) & mask);
  end

endmodule

// File: rtl/pix_color_expand.sv
module pix_color_expand
  import pix_unpack_pkg::*;
(
  input  logic [23:0] raw,
  input  layout_e     layout,
  input  logic        swap,
  output logic [7:0]  idx,
  output logic [7:0]  r,
  output logic [7:0]  g,
  output logic [7:0]  b
);

  logic [7:0] c_lo, c_mid, c_hi;

  always_comb begin
    idx   = 8'd0;
    c_lo  = 8'd0;
    c_mid = 8'd0;
    c_hi  = 8'd0;
    case (layout)
      LAY_PAL:  idx = raw[7:0];
      LAY_1555: begin
        c_lo  = {raw[4:0],   raw[4:2]};
        c_mid = {raw[9:5],   raw[9:7]};
        c_hi  = {raw[14:10], raw[14:12]};
      end
      LAY_565: begin
        c_lo  = {raw[4:0],   raw[4:2]};
        c_mid = {raw[10:5],  raw[10:9]};
        c_hi  = {raw[15:11], raw[15:13]};
      end
      LAY_444: begin
        c_lo  = {raw[3:0],  raw[3:0]};
        c_mid = {raw[7:4],  raw[7:4]};
        c_hi  = {raw[11:8], raw[11:8]};
      end
      default: begin
        c_lo  = raw[7:0];
        c_mid = raw[15:8];
        c_hi  = raw[23:16];
      end
    endcase
    r = swap ? c_hi : c_lo;
    g = c_mid;
    b = swap ? c_lo : c_hi;
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter bit LATER_VARIANT = 1'b0,
  parameter int COLS_W        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_code,
  input  logic              swap_rb,
  input  logic              be_byte,
  input  logic              be_pixel,
  input  logic [1:0]        mux_sel,
  input  logic [COLS_W-1:0] panel_cols,
  output logic [COLS_W+1:0] line_bytes,
  input  logic [31:0]       word_in,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              pix_valid,
  output logic [7:0]        pix_index,
  output logic [7:0]        pix_r,
  output logic [7:0]        pix_g,
  output logic [7:0]        pix_b
);

  localparam int LB_W = COLS_W + 2;

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pix_cfg_t          cfg_in, cfg_q;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [23:0]       raw;

  pix_fmt_decode #(.LATER(LATER_VARIANT)) u_dec (
    .fmt     (fmt_code),
    .bgr     (swap_rb),
    .be_byte (be_byte),
    .be_pix  (be_pixel),
    .mux     (mux_sel),
    .cfg     (cfg_in)
  );

  pix_word_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (word_valid),
    .in_data  (word_in),
    .cfg_in   (cfg_in),
    .in_ready (word_ready),
    .busy     (pix_valid),
    .word_q   (word_q),
    .cfg_q    (cfg_q),
    .cnt_q    (cnt_q)
  );

  pix_extract u_ext (
    .word (word_q),
    .cfg  (cfg_q),
    .idx  (cnt_q),
    .raw  (raw)
  );

  pix_color_expand u_col (
    .raw    (raw),
    .layout (cfg_q.layout),
    .swap   (cfg_q.swap),
    .idx    (pix_index),
    .r      (pix_r),
    .g      (pix_g),
    .b      (pix_b)
  );

  always_comb begin
    case (fmt_code)
      3'd0:    line_bytes = LB_W'(panel_cols >> 3);
      3'd1:    line_bytes = LB_W'(panel_cols >> 2);
      3'd2:    line_bytes = LB_W'(panel_cols >> 1);
      3'd3:    line_bytes = LB_W'(panel_cols);
      3'd5:    line_bytes = LB_W'(panel_cols) << 2;
      default: line_bytes = LB_W'(panel_cols) << 1;
    endcase
  end

  assert_pal_no_rgb_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && cfg_q.layout == LAY_PAL) |-> (pix_r == 8'd0 && pix_g == 8'd0 && pix_b == 8'd0));

  assert_direct_no_idx_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pix_valid && cfg_q.layout != LAY_PAL) |-> (pix_index == 8'd0));

endmodule

// File: tb/tb_pix_unpack.sv
module tb_pix_unpack;

  localparam int CLK_PERIOD = 10;
  localparam int COLS_W     = 12;

  logic              clk;
  logic              rst_n;
  logic [2:0]        fmt_code;
  logic              swap_rb, be_byte, be_pixel;
  logic [1:0]        mux_sel;
  logic [COLS_W-1:0] panel_cols;
  logic [COLS_W+1:0] line_bytes, line_bytes_l;
  logic [31:0]       word_in;
  logic              word_valid;
  logic              word_ready, word_ready_l;
  logic              pix_valid, pix_valid_l;
  logic [7:0]        pix_index, pix_r, pix_g, pix_b;
  logic [7:0]        pix_index_l, pix_r_l, pix_g_l, pix_b_l;

  pix_unpack #(.LATER_VARIANT(1'b0), .COLS_W(COLS_W)) dut (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .swap_rb(swap_rb),
    .be_byte(be_byte), .be_pixel(be_pixel), .mux_sel(mux_sel),
    .panel_cols(panel_cols), .line_bytes(line_bytes), .word_in(word_in),
    .word_valid(word_valid), .word_ready(word_ready), .pix_valid(pix_valid),
    .pix_index(pix_index), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b));

  pix_unpack #(.LATER_VARIANT(1'b1), .COLS_W(COLS_W)) dut_l (
    .clk(clk), .rst_n(rst_n), .fmt_code(fmt_code), .swap_rb(swap_rb),
    .be_byte(be_byte), .be_pixel(be_pixel), .mux_sel(mux_sel),
    .panel_cols(panel_cols), .line_bytes(line_bytes_l), .word_in(word_in),
    .word_valid(word_valid), .word_ready(word_ready_l), .pix_valid(pix_valid_l),
    .pix_index(pix_index_l), .pix_r(pix_r_l), .pix_g(pix_g_l), .pix_b(pix_b_l));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        later;
    logic [2:0]  fmt;
    logic        bgr;
    logic        beb;
    logic        bep;
    logic [1:0]  mux;
    logic [31:0] word;
    logic [4:0]  k;
    logic [31:0] exp;   // {index, r, g, b}
    logic [5:0]  n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0,3'd0,1'b0,1'b0,1'b0,2'd0,32'h0000_0004,5'd2,32'h0100_0000,6'd32,4'd3},  // R3 1bpp
    '{1'b0,3'd0,1'b0,1'b0,1'b1,2'd0,32'h0000_0080,5'd0,32'h0100_0000,6'd32,4'd5},  // R5
    '{1'b0,3'd1,1'b0,1'b0,1'b0,2'd0,32'h0000_0030,5'd2,32'h0300_0000,6'd16,4'd3},  // R3 2bpp
    '{1'b0,3'd2,1'b0,1'b0,1'b0,2'd0,32'h8765_4321,5'd5,32'h0600_0000,6'd8, 4'd3},  // R3 4bpp
    '{1'b0,3'd2,1'b0,1'b0,1'b1,2'd0,32'h8765_4321,5'd0,32'h0200_0000,6'd8, 4'd5},  // R5
    '{1'b0,3'd3,1'b0,1'b0,1'b0,2'd0,32'hAABB_CCDD,5'd1,32'hCC00_0000,6'd4, 4'd6},  // R6
    '{1'b0,3'd3,1'b0,1'b0,1'b1,2'd0,32'hAABB_CCDD,5'd1,32'hCC00_0000,6'd4, 4'd5},  // R5 no effect at 8
    '{1'b0,3'd3,1'b0,1'b1,1'b0,2'd0,32'hAABB_CCDD,5'd0,32'hAA00_0000,6'd4, 4'd4},  // R4
    '{1'b0,3'd2,1'b0,1'b1,1'b1,2'd0,32'h8765_4321,5'd0,32'h0700_0000,6'd8, 4'd4},  // R4 priority
    '{1'b0,3'd5,1'b0,1'b0,1'b0,2'd0,32'h0033_2211,5'd0,32'h0011_2233,6'd1, 4'd7},  // R7
    '{1'b0,3'd5,1'b1,1'b0,1'b0,2'd0,32'h0033_2211,5'd0,32'h0033_2211,6'd1, 4'd7},  // R7 swap
    '{1'b0,3'd5,1'b0,1'b1,1'b0,2'd0,32'h1122_3300,5'd0,32'h0011_2233,6'd1, 4'd4},  // R4
    '{1'b1,3'd4,1'b0,1'b0,1'b0,2'd0,32'h0000_C03F,5'd0,32'h00FF_0884,6'd2, 4'd8},  // R8
    '{1'b1,3'd4,1'b0,1'b0,1'b0,2'd0,32'hC03F_0000,5'd1,32'h00FF_0884,6'd2, 4'd8},  // R8
    '{1'b1,3'd4,1'b1,1'b0,1'b0,2'd0,32'h0000_C03F,5'd0,32'h0084_08FF,6'd2, 4'd8},  // R8 swap
    '{1'b1,3'd6,1'b0,1'b0,1'b0,2'd0,32'h0000_F423,5'd0,32'h0018_86F7,6'd2, 4'd9},  // R9
    '{1'b1,3'd6,1'b1,1'b0,1'b0,2'd0,32'h0000_F423,5'd0,32'h00F7_8618,6'd2, 4'd9},  // R9
    '{1'b1,3'd7,1'b0,1'b0,1'b0,2'd0,32'h0000_FA5C,5'd0,32'h00CC_55AA,6'd2, 4'd9},  // R9 444
    '{1'b1,3'd4,1'b0,1'b1,1'b0,2'd0,32'h3FC0_0000,5'd0,32'h00FF_0884,6'd2, 4'd4},  // R4 16-bit
    '{1'b0,3'd4,1'b0,1'b0,1'b0,2'd1,32'h0000_C03F,5'd0,32'h00FF_0884,6'd2, 4'd10}, // R10 mux 1
    '{1'b0,3'd4,1'b0,1'b0,1'b0,2'd3,32'h0000_F423,5'd0,32'h00F7_8618,6'd2, 4'd10}, // R10 mux 3
    '{1'b0,3'd4,1'b1,1'b0,1'b0,2'd3,32'h0000_F423,5'd0,32'h00F7_8618,6'd2, 4'd10}, // R10 mux 3
    '{1'b0,3'd4,1'b0,1'b0,1'b0,2'd0,32'h0000_F423,5'd0,32'h0018_86F7,6'd2, 4'd10}, // R10 mux 0
    '{1'b0,3'd4,1'b1,1'b0,1'b0,2'd2,32'h0000_F423,5'd0,32'h00F7_8618,6'd2, 4'd10}, // R10 mux 2
    '{1'b0,3'd6,1'b0,1'b0,1'b0,2'd1,32'h0000_C03F,5'd0,32'h00FF_0884,6'd2, 4'd10}, // R10 code 6
    '{1'b1,3'd4,1'b0,1'b0,1'b0,2'd3,32'h0000_C03F,5'd0,32'h00FF_0884,6'd2, 4'd11}, // R11
    '{1'b1,3'd6,1'b0,1'b0,1'b0,2'd1,32'h0000_F423,5'd0,32'h0018_86F7,6'd2, 4'd11}, // R11
    '{1'b0,3'd7,1'b0,1'b0,1'b0,2'd3,32'h0000_F423,5'd0,32'h00F7_8618,6'd2, 4'd10}  // R10 code 7
  };

  function automatic logic [31:0] pix_of(input logic later);
    return later ? {pix_index_l, pix_r_l, pix_g_l, pix_b_l}
                 : {pix_index, pix_r, pix_g, pix_b};
  endfunction

  function automatic logic valid_of(input logic later);
    return later ? pix_valid_l : pix_valid;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] got;
    int n;
    @(negedge clk);
    fmt_code = v.fmt; swap_rb = v.bgr; be_byte = v.beb; be_pixel = v.bep;
    mux_sel = v.mux; word_in = v.word; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    n = 0;
    got = '0;
    while (valid_of(v.later)) begin
      if (n == int'(v.k)) got = pix_of(v.later);
      n++;
      @(negedge clk);
    end
    while (pix_valid || pix_valid_l) @(negedge clk);
    chk($sformatf("R%0d pixel", v.req), 64'(got), 64'(v.exp));
    chk("R2 pixel count", 64'(n), 64'(v.n));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fmt_code = 3'd0; swap_rb = 1'b0; be_byte = 1'b0; be_pixel = 1'b0;
    mux_sel = 2'd0; panel_cols = 12'd640; word_in = '0; word_valid = 1'b0;
    repeat (3) @(negedge clk);
    // Reset state (R1)
    chk("R1 reset pix_valid", 64'(pix_valid), 64'd0);
    chk("R1 reset word_ready", 64'(word_ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12 bytes per line, width 640
    @(negedge clk);
    fmt_code = 3'd0; #1 chk("R12 1bpp", 64'(line_bytes), 64'd80);
    fmt_code = 3'd1; #1 chk("R12 2bpp", 64'(line_bytes), 64'd160);
    fmt_code = 3'd2; #1 chk("R12 4bpp", 64'(line_bytes), 64'd320);
    fmt_code = 3'd3; #1 chk("R12 8bpp", 64'(line_bytes), 64'd640);
    fmt_code = 3'd4; #1 chk("R12 16bpp", 64'(line_bytes), 64'd1280);
    fmt_code = 3'd5; #1 chk("R12 32bpp", 64'(line_bytes), 64'd2560);
    fmt_code = 3'd7; #1 chk("R12 12bpp", 64'(line_bytes_l), 64'd1280);

    // R1 back-to-back at 8 bpp: ready only on last pixel
    @(negedge clk);
    fmt_code = 3'd3; swap_rb = 1'b0; be_byte = 1'b0; be_pixel = 1'b0;
    word_in = 32'h0403_0201; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_in = 32'h0807_0605;
    chk("R1 ready low mid-word", 64'(word_ready), 64'd0);
    chk("R1 pixel A0", 64'(pix_index), 64'h01);
    repeat (3) @(negedge clk);
    chk("R1 pixel A3", 64'(pix_index), 64'h04);
    chk("R1 ready on last", 64'(word_ready), 64'd1);
    @(negedge clk);
    word_valid = 1'b0;
    chk("R1 next word no bubble", 64'({pix_valid, pix_index}), 64'h105);
    while (pix_valid || pix_valid_l) @(negedge clk);

    // R1 back-to-back at 32 bpp: every cycle accepts
    fmt_code = 3'd5; word_in = 32'h0003_0201; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 32bpp first", 64'({pix_r, pix_g, pix_b}), 64'h010203);
    chk("R1 32bpp ready", 64'(word_ready), 64'd1);
    word_in = 32'h0006_0504;
    @(negedge clk);
    word_valid = 1'b0;
    chk("R1 32bpp second", 64'({pix_valid, pix_r, pix_g, pix_b}), 64'h1040506);
    @(negedge clk);
    chk("R1 32bpp drained", 64'(pix_valid), 64'd0);
    while (pix_valid_l) @(negedge clk);

    // R13 inputs changed during unpacking
    fmt_code = 3'd3; word_in = 32'hAABB_CCDD; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0; fmt_code = 3'd5; be_byte = 1'b1; swap_rb = 1'b1;
    @(negedge clk);
    chk("R13 held format pixel", 64'({pix_index, pix_r, pix_g, pix_b}), 64'hCC00_0000);
    repeat (2) @(negedge clk);
    chk("R13 held count last", 64'({pix_valid, pix_index}), 64'h1AA);
    @(negedge clk);
    chk("R13 held count end", 64'(pix_valid), 64'd0);
    while (pix_valid_l) @(negedge clk);
    be_byte = 1'b0; swap_rb = 1'b0;

    // R1 reset during unpacking clears output
    fmt_code = 3'd0; word_in = 32'hFFFF_FFFF; word_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 reset mid-word", 64'({pix_valid, word_ready}), 64'b01);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule